// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block sits beside the core of an 8-bit processor with a 16-bit address space. It stores and reloads the whole programmer-visible register set when an interrupt is accepted and when the return-from-interrupt instruction runs. Decode logic raises an instruction-boundary strobe when the instruction in progress has finished. At that boundary, a pending interrupt request or a decoded return strobe starts a sequence. The register values offered on the snapshot inputs are captured in that same cycle.

On entry the block writes nine bytes, one per cycle, onto a stack that grows downward. It then reads the two-byte vector and issues the first opcode fetch at the new program counter. On return it reads the nine bytes back, last-stored first, and then fetches at the recovered return address. During the fetch cycle the reload values are presented on the outputs together with a strobe, and the core copies them into its registers. Memory is a byte-wide port whose read data is valid in the same cycle as the address.

Top module: `ctx_stack_seq`

## Requirements
- R1: Two or more cycles after `rst` is removed, with no boundary strobe, `busy`, `mem_we`, `mem_re` and `fetch` are all low.
- R2: A sequence starts only in an idle cycle in which `insn_done` is high. `irq_req` or `rti_req` without `insn_done` leaves the bus idle.
- R3: An interrupt sequence writes one byte per cycle, starting the cycle after the start cycle. Byte k (k = 0..8) goes to address SP−k, where SP is the stack pointer snapshot. The byte order is PC[7:0], PC[15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], A, B, CCR.
- R4: After the ninth write, two read cycles fetch the vector. The high byte comes from the vector address with bit 0 forced to 0, and the low byte from the same address with bit 0 forced to 1. The new PC is {high, low}.
- R5: The cycle after the last read of either sequence is a fetch cycle. In it `mem_re` and `fetch` are high, `mem_addr` equals the new PC, and `pc_out` carries that PC.
- R6: In the fetch cycle `sp_out` equals SP−9 after an interrupt and SP+9 after a return.
- R7: A return sequence reads addresses SP+1 through SP+9, one per cycle. The bytes are taken as CCR, B, A, X[15:8], X[7:0], Y[15:8], Y[7:0], PC[15:8], PC[7:0]. In the fetch cycle `restore_all` is high and all register outputs carry the reassembled values.
- R8: When `rti_req` and `irq_req` are both high at a boundary, the return sequence runs. The interrupt stays pending and starts at the next boundary after the block is idle again.
- R9: While `busy` is high, the boundary, request and snapshot inputs have no effect. The bytes written and the values presented at the fetch cycle come from the snapshot captured in the start cycle.
- R10: `busy` rises the cycle after the start cycle and stays high through the fetch cycle: 12 cycles for an interrupt and 10 for a return. It is low in the cycle that follows.
- R11: All stack and vector addresses wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_req | input | 1 | Pending, unmasked interrupt request |
| rti_req | input | 1 | Return-from-interrupt decoded at this boundary |
| vec_addr | input | 16 | Address of the vector for the interrupt being taken |
| sp_in | input | 16 | Stack pointer snapshot |
| pc_in | input | 16 | Program counter snapshot (return address) |
| x_in | input | 16 | X index register snapshot |
| y_in | input | 16 | Y index register snapshot |
| a_in | input | 8 | Accumulator A snapshot |
| b_in | input | 8 | Accumulator B snapshot |
| ccr_in | input | 8 | Condition code register snapshot |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| fetch | output | 1 | First opcode fetch at the new PC; reload strobe |
| restore_all | output | 1 | With `fetch`: the whole register file is reloaded |
| pc_out | output | 16 | Program counter reload value |
| sp_out | output | 16 | Stack pointer reload value |
| x_out | output | 16 | X reload value |
| y_out | output | 16 | Y reload value |
| a_out | output | 8 | A reload value |
| b_out | output | 8 | B reload value |
| ccr_out | output | 8 | CCR reload value |

## Verification
Two events can meet at one instruction boundary: an interrupt request and a decoded return. The bench provokes this by raising `insn_done`, `irq_req` and `rti_req` together over a frame stored earlier. It then holds the request high with no boundary until the restore finishes. The run is judged by requiring the complete pull sequence first and then a fresh push at the next boundary. A second case holds the boundary and request high continuously, so that a new start follows the fetch cycle directly.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int NSLOT  = 9;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t LAST_SLOT = slot_t'(NSLOT - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_VEC_HI,
        S_VEC_LO,
        S_PULL,
        S_FETCH
    } seq_state_e;

    typedef struct packed {
        addr_t pc;
        addr_t iy;
        addr_t ix;
        byte_t acca;
        byte_t accb;
        byte_t flags;
    } ctx_t;

    // Byte held in a given push slot (slot 0 is written first).
    function automatic byte_t slot_byte(ctx_t c, slot_t s);
        byte_t r;
        case (s)
            slot_t'(0): r = c.pc[BYTE_W-1:0];
            slot_t'(1): r = c.pc[ADDR_W-1:BYTE_W];
            slot_t'(2): r = c.iy[BYTE_W-1:0];
            slot_t'(3): r = c.iy[ADDR_W-1:BYTE_W];
            slot_t'(4): r = c.ix[BYTE_W-1:0];
            slot_t'(5): r = c.ix[ADDR_W-1:BYTE_W];
            slot_t'(6): r = c.acca;
            slot_t'(7): r = c.accb;
            default:    r = c.flags;
        endcase
        return r;
    endfunction

    // Place a byte read from the stack back into its slot.
    function automatic ctx_t slot_insert(ctx_t c, slot_t s, byte_t d);
        ctx_t r;
        r = c;
        case (s)
            slot_t'(0): r.pc[BYTE_W-1:0]      = d;
            slot_t'(1): r.pc[ADDR_W-1:BYTE_W] = d;
            slot_t'(2): r.iy[BYTE_W-1:0]      = d;
            slot_t'(3): r.iy[ADDR_W-1:BYTE_W] = d;
            slot_t'(4): r.ix[BYTE_W-1:0]      = d;
            slot_t'(5): r.ix[ADDR_W-1:BYTE_W] = d;
            slot_t'(6): r.acca                = d;
            slot_t'(7): r.accb                = d;
            default:    r.flags               = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       insn_done,
    input  logic       irq_req,
    input  logic       rti_req,
    output seq_state_e state,
    output slot_t      slot,
    output logic       rti_mode,
    output logic       start
);

    assign start = (state == S_IDLE) && insn_done && (irq_req || rti_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            slot     <= '0;
            rti_mode <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        rti_mode <= rti_req;
                        slot     <= '0;
                        state    <= rti_req ? S_PULL : S_PUSH;
                    end
                end
                S_PUSH: begin
                    if (slot == LAST_SLOT) state <= S_VEC_HI;
                    else                   slot  <= slot + slot_t'(1);
                end
                S_VEC_HI: state <= S_VEC_LO;
                S_VEC_LO: state <= S_FETCH;
                S_PULL: begin
                    if (slot == LAST_SLOT) state <= S_FETCH;
                    else                   slot  <= slot + slot_t'(1);
                end
                S_FETCH: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: without a boundary strobe the sequencer stays idle
    a_r2_wait_boundary: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !insn_done) |=> (state == S_IDLE));

    // R10: the fetch cycle is always the last busy cycle
    a_r10_fetch_ends: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (state == S_IDLE));

    // R9: the mode chosen at start is held for the whole sequence
    a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(rti_mode));

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  seq_state_e state,
    input  addr_t      sp_in,
    input  addr_t      vec_in,
    input  addr_t      fetch_pc,
    output addr_t      mem_addr,
    output addr_t      sp_q
);

    addr_t vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            vec_q <= '0;
        end else if (start) begin
            sp_q  <= sp_in;
            vec_q <= vec_in;
        end else if (state == S_PUSH) begin
            sp_q <= sp_q - addr_t'(1);
        end else if (state == S_PULL) begin
            sp_q <= sp_q + addr_t'(1);
        end
    end

    always_comb begin
        case (state)
            S_PUSH:   mem_addr = sp_q;
            S_PULL:   mem_addr = sp_q + addr_t'(1);
            S_VEC_HI: mem_addr = vec_q & ~addr_t'(1);
            S_VEC_LO: mem_addr = vec_q | addr_t'(1);
            S_FETCH:  mem_addr = fetch_pc;
            default:  mem_addr = sp_q;
        endcase
    end

    // R11: stack pointer moves by exactly one per stack cycle, modulo 2^16
    a_r11_sp_step: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == S_PUSH && state != S_IDLE) |-> (sp_q == $past(sp_q) - addr_t'(1)));

endmodule

// File: rtl/ctx_file.sv
module ctx_file
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  seq_state_e state,
    input  slot_t      slot,
    input  ctx_t       snap,
    input  byte_t      rd_byte,
    output ctx_t       ctx_q,
    output byte_t      wr_byte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (start) begin
            ctx_q <= snap;
        end else begin
            case (state)
                S_PULL:   ctx_q <= slot_insert(ctx_q, LAST_SLOT - slot, rd_byte);
                S_VEC_HI: ctx_q.pc[ADDR_W-1:BYTE_W] <= rd_byte;
                S_VEC_LO: ctx_q.pc[BYTE_W-1:0]      <= rd_byte;
                default:  ctx_q <= ctx_q;
            endcase
        end
    end

    assign wr_byte = slot_byte(ctx_q, slot);

    // R9: the captured context cannot change while it is being stored
    a_r9_ctx_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == S_PUSH) |=> $stable(ctx_q));

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_done,
    input  logic        irq_req,
    input  logic        rti_req,
    input  logic [15:0] vec_addr,
    input  logic [15:0] sp_in,
    input  logic [15:0] pc_in,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  b_in,
    input  logic [7:0]  ccr_in,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        fetch,
    output logic        restore_all,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [15:0] x_out,
    output logic [15:0] y_out,
    output logic [7:0]  a_out,
    output logic [7:0]  b_out,
    output logic [7:0]  ccr_out
);

    seq_state_e state;
    slot_t      slot;
    logic       rti_mode;
    logic       start;
    ctx_t       snap;
    ctx_t       ctx_q;
    addr_t      sp_q;

    assign snap = '{pc: pc_in, iy: y_in, ix: x_in, acca: a_in, accb: b_in, flags: ccr_in};

    ctx_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .rti_req   (rti_req),
        .state     (state),
        .slot      (slot),
        .rti_mode  (rti_mode),
        .start     (start)
    );

    ctx_addr_gen u_addr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .state    (state),
        .sp_in    (sp_in),
        .vec_in   (vec_addr),
        .fetch_pc (ctx_q.pc),
        .mem_addr (mem_addr),
        .sp_q     (sp_q)
    );

    ctx_file u_file (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .state   (state),
        .slot    (slot),
        .snap    (snap),
        .rd_byte (mem_rdata),
        .ctx_q   (ctx_q),
        .wr_byte (mem_wdata)
    );

    assign mem_we      = (state == S_PUSH);
    assign mem_re      = (state == S_PULL) || (state == S_VEC_HI) ||
                         (state == S_VEC_LO) || (state == S_FETCH);
    assign busy        = (state != S_IDLE);
    assign fetch       = (state == S_FETCH);
    assign restore_all = fetch && rti_mode;

    assign pc_out  = ctx_q.pc;
    assign sp_out  = sp_q;
    assign x_out   = ctx_q.ix;
    assign y_out   = ctx_q.iy;
    assign a_out   = ctx_q.acca;
    assign b_out   = ctx_q.accb;
    assign ccr_out = ctx_q.flags;

    // R3: consecutive stack writes walk downward by one byte
    a_r3_write_descends: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R7: consecutive stack reads walk upward by one byte
    a_r7_read_ascends: assert property (@(posedge clk) disable iff (rst)
        (state == S_PULL && $past(state) == S_PULL) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R4: vector low byte is read from the odd partner of the high byte address
    a_r4_vec_pair: assert property (@(posedge clk) disable iff (rst)
        (state == S_VEC_LO) |-> (mem_addr[0] && !$past(mem_addr[0]) &&
                                 mem_addr[15:1] == $past(mem_addr[15:1])));

    // R5: the opcode fetch always follows a read cycle
    a_r5_fetch_after_read: assert property (@(posedge clk) disable iff (rst)
        fetch |-> $past(mem_re));

    // R10: every busy cycle drives exactly one bus operation
    a_r10_busy_bus: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((mem_we || mem_re) && !(mem_we && mem_re)));

endmodule

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, insn_done, irq_req, rti_req;
    logic [15:0] vec_addr, sp_in, pc_in, x_in, y_in;
    logic [7:0]  a_in, b_in, ccr_in;
    logic [15:0] mem_addr, pc_out, sp_out, x_out, y_out;
    logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, ccr_out;
    logic        mem_we, mem_re, busy, fetch, restore_all;

    ctx_stack_seq uut (
        .clk(clk), .rst(rst), .insn_done(insn_done), .irq_req(irq_req), .rti_req(rti_req),
        .vec_addr(vec_addr), .sp_in(sp_in), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
        .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .fetch(fetch), .restore_all(restore_all),
        .pc_out(pc_out), .sp_out(sp_out), .x_out(x_out), .y_out(y_out),
        .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out)
    );

    logic [7:0] mem [0:65535];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    typedef struct {
        bit          we, re, fe, all;
        logic [15:0] addr, pc, sp, x, y;
        logic [7:0]  wd, a, b, f;
    } op_t;

    op_t   q[$];
    string tq[$];
    string scen;
    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_cycles = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic plan(bit rti);
        op_t         o;
        logic [15:0] s;
        logic [15:0] np;
        logic [15:0] va;
        logic [7:0]  by [9];
        s  = sp_in;
        va = {vec_addr[15:1], 1'b0};
        if (!rti) begin
            by = '{pc_in[7:0], pc_in[15:8], y_in[7:0], y_in[15:8],
                   x_in[7:0], x_in[15:8], a_in, b_in, ccr_in};
            for (int k = 0; k < 9; k++) begin
                o = '{default: 0}; o.we = 1; o.addr = s - 16'(k); o.wd = by[k];
                q.push_back(o); tq.push_back({"R3/", scen});
            end
            o = '{default: 0}; o.re = 1; o.addr = va;
            q.push_back(o); tq.push_back({"R4/", scen});
            o.addr = va | 16'd1;
            q.push_back(o); tq.push_back({"R4/", scen});
            np = {mem[va], mem[va | 16'd1]};
            o = '{default: 0}; o.re = 1; o.fe = 1; o.addr = np; o.pc = np; o.sp = s - 16'd9;
            o.x = x_in; o.y = y_in; o.a = a_in; o.b = b_in; o.f = ccr_in;
            q.push_back(o); tq.push_back({"R5/", scen});
        end else begin
            for (int j = 0; j < 9; j++) begin
                by[j] = mem[s + 16'(j + 1)];
                o = '{default: 0}; o.re = 1; o.addr = s + 16'(j + 1);
                q.push_back(o); tq.push_back({"R7/", scen});
            end
            np = {by[7], by[8]};
            o = '{default: 0}; o.re = 1; o.fe = 1; o.all = 1; o.addr = np; o.pc = np;
            o.sp = s + 16'd9; o.x = {by[3], by[4]}; o.y = {by[5], by[6]};
            o.a = by[2]; o.b = by[1]; o.f = by[0];
            q.push_back(o); tq.push_back({"R5/", scen});
        end
    endtask

    // Check this cycle against the model, then drive the boundary inputs.
    task automatic cyc(bit ins, bit irq, bit rti);
        op_t   e;
        string t;
        bit    act;
        act = (q.size() > 0);
        if (!act) begin
            chk({scen, "/R10"}, "busy", busy, 0);
            chk(scen, "mem_we", mem_we, 0);
            chk(scen, "mem_re", mem_re, 0);
            chk(scen, "fetch", fetch, 0);
        end else begin
            e = q.pop_front();
            t = tq.pop_front();
            chk("R10", "busy", busy, 1);
            chk(t, "mem_we", mem_we, e.we);
            chk(t, "mem_re", mem_re, e.re);
            chk(t, "fetch", fetch, e.fe);
            chk(t, "mem_addr", mem_addr, e.addr);
            if (e.we) chk(t, "mem_wdata", mem_wdata, e.wd);
            if (e.fe) begin
                chk("R5", "pc_out", pc_out, e.pc);
                chk("R6", "sp_out", sp_out, e.sp);
                chk("R7", "restore_all", restore_all, e.all);
                chk("R7", "x_out", x_out, e.x);
                chk("R7", "y_out", y_out, e.y);
                chk("R7", "a_out", a_out, e.a);
                chk("R7", "b_out", b_out, e.b);
                chk("R7", "ccr_out", ccr_out, e.f);
            end
        end
        insn_done = ins;
        irq_req   = irq;
        rti_req   = rti;
        if (!act && ins && (irq || rti)) plan(rti);
        @(negedge clk);
    endtask

    task automatic set_ctx(logic [15:0] sp, logic [15:0] pc, logic [15:0] x,
                           logic [15:0] y, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        sp_in = sp; pc_in = pc; x_in = x; y_in = y; a_in = a; b_in = b; ccr_in = f;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        n_cycles++;
        if (n_cycles > 5000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected below 5000", n_cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h5A;
        rst = 1'b1; insn_done = 0; irq_req = 0; rti_req = 0; vec_addr = 16'hFFF6;
        set_ctx(16'h01F0, 16'h8123, 16'h4455, 16'h6677, 8'h11, 8'h22, 8'hC4);
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        scen = "R1";
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R1", "busy after reset", busy, 0);

        // R2: requests without a boundary
        scen = "R2";
        repeat (3) cyc(0, 1, 0);
        repeat (2) cyc(0, 0, 1);

        // R3: interrupt entry, then R9: noise on every input while busy
        scen = "R3";
        cyc(1, 1, 0);
        scen = "R9";
        for (int i = 0; i < 12; i++) begin
            set_ctx(16'h1000 + 16'(i), 16'h2222, 16'h3333, 16'h4444, 8'(i), 8'h99, 8'h00);
            vec_addr = 16'hFFF0;
            cyc(1, i[0], i[1]);
        end
        repeat (2) cyc(0, 0, 0);

        // R7: return from the frame just stored
        scen = "R7";
        vec_addr = 16'hFFF6;
        set_ctx(16'h01E7, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00);
        cyc(1, 0, 1);
        repeat (12) cyc(0, 0, 0);

        // R8: return and interrupt at the same boundary
        scen = "R8";
        cyc(1, 1, 1);
        repeat (10) cyc(0, 1, 0);
        set_ctx(16'h0200, 16'hA5A5, 16'h1234, 16'h5678, 8'h9A, 8'hBC, 8'h0D);
        cyc(1, 1, 0);
        repeat (14) cyc(0, 0, 0);

        // R11: stack wrap below zero and back, odd vector address
        scen = "R11";
        vec_addr = 16'hBFFB;
        set_ctx(16'h0003, 16'hC0DE, 16'hBEEF, 16'hF00D, 8'h5C, 8'hA3, 8'h81);
        cyc(1, 1, 0);
        repeat (13) cyc(0, 0, 0);
        set_ctx(16'hFFFA, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00);
        cyc(1, 0, 1);
        repeat (12) cyc(0, 0, 0);

        // R10: boundary and request held high, back-to-back entries
        scen = "R10";
        vec_addr = 16'hFFF6;
        set_ctx(16'h0300, 16'h7001, 16'h0102, 16'h0304, 8'h05, 8'h06, 8'h07);
        repeat (30) cyc(1, 1, 0);
        repeat (14) cyc(0, 0, 0);

        finish_run();
    end

endmodule